// File: doc/BRIEF.md
# Transmit Dominant Watchdog and Driver Gate

This block sits between the protocol controller and the analog line driver of a CAN-style transceiver front end. It watches the transmit data input, where low means dominant, and a thermal shutdown flag, and decides whether the line driver may pull the bus dominant. A dominant request goes to the analog driver only when the gate is open, the transmit input is low and the transceiver is in its normal operating mode.

Two faults close the gate. The first is a transmit input held low for too long, measured in clock cycles by a parameter. The second is an over-temperature flag. Both lockouts are sticky. Each one opens again only after the transmit input has been seen recessive, so a transmit input stuck low can never drive the bus again by itself. After reset the gate also stays closed until the first clock on which the transmit input is high.

The timeout must be longer than the longest legal dominant run at the slowest supported bit rate of 40 kbit/s. The default of 100000 cycles covers 20 bit times at a 200 MHz clock.

Top module: `txDomGuard`

## Requirements
- R1: While reset is asserted, and after its release until the first rising clock edge that samples `txdIn` high, `drvEn`, `domReq`, `toutLock` and `thermLock` are all 0.
- R2: Once a high `txdIn` has been sampled with no lockout active, `drvEn` is 1 after that edge.
- R3: `domReq` is 1 exactly when `drvEn` is 1, `txdIn` is 0 and `modeNormal` is 1. It follows these inputs within the same cycle.
- R4: `txdIn` sampled low on TIMEOUT_CYCLES-1 consecutive edges does not set `toutLock` and leaves `drvEn` at 1.
- R5: On the edge that samples `txdIn` low for the TIMEOUT_CYCLES-th consecutive time, `toutLock` becomes 1 and `drvEn` becomes 0. This also forces `domReq` to 0.
- R6: A single edge that samples `txdIn` high restarts the consecutive-low count from zero.
- R7: `toutLock` stays at 1 while `txdIn` is sampled low. It clears on the first edge that samples `txdIn` high, and `drvEn` returns to 1 at that edge when no thermal lockout is active.
- R8: An edge that samples `thermalFault` at 1 sets `thermLock` to 1 and `drvEn` to 0.
- R9: `thermLock` clears only on an edge that samples `thermalFault` at 0 and `txdIn` high. It stays set while the fault is present, even with `txdIn` high, and it stays set while `txdIn` is low after the fault has gone.
- R10: `modeNormal` at 0 forces `domReq` to 0. It has no effect on `drvEn`, on the dominant timer or on either lockout flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txdIn | input | 1 | Transmit data; 0 = dominant, 1 = recessive |
| thermalFault | input | 1 | Over-temperature flag from the sensor, active high |
| modeNormal | input | 1 | 1 when the transceiver is in its normal operating mode |
| drvEn | output | 1 | Gate open: driver allowed to assert dominant |
| domReq | output | 1 | Dominant request to the analog driver |
| toutLock | output | 1 | Sticky dominant-timeout lockout flag |
| thermLock | output | 1 | Sticky thermal lockout flag |

## Verification
Low runs are applied at one cycle short of the timeout and at exactly the timeout length. A near-limit run split by a single high cycle checks that the counter restarts rather than keeping its total. The stuck-low sequences continue past the limit, which separates a lockout that releases on txd going high from one that releases on its own. Thermal pulses are applied with txd held high and with txd held low, so the tests show that thermal release needs both the fault gone and a recessive input. Normal mode is switched off while txd is dominant, which shows that mode gating affects the request and nothing else.

// File: rtl/txDomGuardPkg.sv
`timescale 1ns/1ps
package txDomGuardPkg;
  // Strobes from control to the dominant-run counter
  typedef struct packed {
    logic clrRun;  // restart run length
    logic incRun;  // one more dominant sample
  } runStrobeT;
endpackage

// File: rtl/txDomTimer.sv
`timescale 1ns/1ps
module txDomTimer
  import txDomGuardPkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 100000
) (
  input  logic      clk,
  input  logic      rstN,
  input  runStrobeT stb,
  output logic      atLimit
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] SAT_VAL  = CW'(TIMEOUT_CYCLES);
  localparam logic [CW-1:0] LIMIT_M1 = CW'(TIMEOUT_CYCLES - 1);

  logic [CW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      runLen <= '0;
    end else if (stb.clrRun) begin
      runLen <= '0;
    end else if (stb.incRun && (runLen != SAT_VAL)) begin
      runLen <= runLen + 1'b1;
    end
  end

  // Past samples already cover all but the final cycle of the window
  assign atLimit = (runLen >= LIMIT_M1);
endmodule

// File: rtl/txDomCtrl.sv
`timescale 1ns/1ps
module txDomCtrl
  import txDomGuardPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txdIn,
  input  logic      thermalFault,
  input  logic      atLimit,
  output runStrobeT stb,
  output logic      drvEn,
  output logic      toutLock,
  output logic      thermLock
);
  logic armed;
  logic expireNow;
  logic toutNext;
  logic thermNext;

  always_comb begin
    stb.clrRun = txdIn;
    stb.incRun = !txdIn;
  end

  assign expireNow = !txdIn && atLimit;
  // Both lockouts need a recessive sample to release
  assign toutNext  = expireNow || (toutLock && !txdIn);
  assign thermNext = thermalFault || (thermLock && !txdIn);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed     <= 1'b0;
      toutLock  <= 1'b0;
      thermLock <= 1'b0;
    end else begin
      armed     <= armed || txdIn;
      toutLock  <= toutNext;
      thermLock <= thermNext;
    end
  end

  assign drvEn = armed && !toutLock && !thermLock;
endmodule

// File: rtl/txDomGuard.sv
`timescale 1ns/1ps
module txDomGuard
  import txDomGuardPkg::*;
#(
  parameter int unsigned TIMEOUT_CYCLES = 100000
) (
  input  logic clk,
  input  logic rstN,
  input  logic txdIn,
  input  logic thermalFault,
  input  logic modeNormal,
  output logic drvEn,
  output logic domReq,
  output logic toutLock,
  output logic thermLock
);
  runStrobeT runStb;
  logic      atLimit;

  txDomCtrl ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .txdIn        (txdIn),
    .thermalFault (thermalFault),
    .atLimit      (atLimit),
    .stb          (runStb),
    .drvEn        (drvEn),
    .toutLock     (toutLock),
    .thermLock    (thermLock)
  );

  txDomTimer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) timer_i (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (runStb),
    .atLimit (atLimit)
  );

  assign domReq = drvEn && !txdIn && modeNormal;
endmodule

// File: rtl/txDomGuardChk.sv
`timescale 1ns/1ps
module txDomGuardChk (
  input logic clk,
  input logic rstN,
  input logic txdIn,
  input logic thermalFault,
  input logic modeNormal,
  input logic drvEn,
  input logic domReq,
  input logic toutLock,
  input logic thermLock
);
  // R3: a request is only raised for a dominant input
  a_r3_req_needs_dominant: assert property (@(posedge clk) disable iff (!rstN)
    domReq |-> !txdIn);

  // R10: outside normal mode no request
  a_r10_mode_blocks_req: assert property (@(posedge clk) disable iff (!rstN)
    !modeNormal |-> !domReq);

  // R5: timeout lockout only arises from a dominant sample
  a_r5_tout_from_low: assert property (@(posedge clk) disable iff (!rstN)
    $rose(toutLock) |-> !$past(txdIn));

  // R7: timeout lockout only released by a recessive sample
  a_r7_tout_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(toutLock) |-> $past(txdIn));

  // R8: a sampled fault closes the gate
  a_r8_fault_locks: assert property (@(posedge clk) disable iff (!rstN)
    thermalFault |=> (thermLock && !drvEn));

  // R9: thermal release needs fault gone and recessive input
  a_r9_therm_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(thermLock) |-> ($past(txdIn) && !$past(thermalFault)));

  // R5: any lockout keeps the driver off
  a_r5_lock_disables: assert property (@(posedge clk) disable iff (!rstN)
    (toutLock || thermLock) |-> !drvEn);
endmodule

bind txDomGuard txDomGuardChk chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .txdIn        (txdIn),
  .thermalFault (thermalFault),
  .modeNormal   (modeNormal),
  .drvEn        (drvEn),
  .domReq       (domReq),
  .toutLock     (toutLock),
  .thermLock    (thermLock)
);

// File: tb/txDomGuard_tb_top.sv
`timescale 1ns/1ps
module txDomGuard_tb_top;
  localparam int unsigned TO = 20;

  typedef struct {
    logic [3:0] expv;  // {drvEn, domReq, toutLock, thermLock}
    string      tag;
  } itemT;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txdIn = 1'b0;
  logic thermalFault = 1'b0;
  logic modeNormal = 1'b1;
  logic drvEn, domReq, toutLock, thermLock;

  itemT sbq[$];
  int   nVec = 0;
  int   nBad = 0;
  bit   done = 1'b0;

  // reference model state
  bit mArmed, mTout, mTherm;
  int mRun;

  always #2.5 clk = ~clk;

  txDomGuard #(.TIMEOUT_CYCLES(TO)) dut_i (
    .clk(clk), .rstN(rstN), .txdIn(txdIn), .thermalFault(thermalFault),
    .modeNormal(modeNormal), .drvEn(drvEn), .domReq(domReq),
    .toutLock(toutLock), .thermLock(thermLock)
  );

  // driver: apply one cycle of stimulus, predict result after next edge
  task automatic step(input logic rst, input logic t, input logic f,
                      input logic m, input string tag);
    itemT it;
    bit drv;
    @(negedge clk);
    rstN = !rst; txdIn = t; thermalFault = f; modeNormal = m;
    if (rst) begin
      mArmed = 0; mTout = 0; mTherm = 0; mRun = 0;
    end else begin
      mRun   = t ? 0 : mRun + 1;
      mTout  = (mRun >= TO) || (mTout && !t);
      mTherm = f || (mTherm && !t);
      mArmed = mArmed || t;
    end
    drv = mArmed && !mTout && !mTherm;
    it.expv = {drv, drv && !t && m, mTout, mTherm};
    it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic run(input int n, input logic t, input logic f,
                     input logic m, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, t, f, m, tag);
  endtask

  // monitor: compare after each edge settles
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sbq.size() > 0) begin
        itemT it;
        logic [3:0] act;
        it = sbq.pop_front();
        act = {drvEn, domReq, toutLock, thermLock};
        nVec++;
        if (act !== it.expv) begin
          nBad++;
          $display("FAIL %s: {drvEn,domReq,toutLock,thermLock} actual %b expected %b",
                   it.tag, act, it.expv);
        end
      end
    end
  end

  initial begin
    #100000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    // R1: reset state, then stays closed while txd low after release
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 1'b1, "R1");
    run(3, 1'b0, 1'b0, 1'b1, "R1");
    // R2: first recessive sample opens the gate
    run(2, 1'b1, 1'b0, 1'b1, "R2");
    // R3: request follows dominant txd
    run(3, 1'b0, 1'b0, 1'b1, "R3");
    run(1, 1'b1, 1'b0, 1'b1, "R3");
    // R10: mode off blocks request, timer continues
    run(4, 1'b0, 1'b0, 1'b0, "R10");
    run(1, 1'b1, 1'b0, 1'b0, "R10");
    // R4: one short of the limit
    run(TO - 1, 1'b0, 1'b0, 1'b1, "R4");
    run(1, 1'b1, 1'b0, 1'b1, "R4");
    // R6: split run does not accumulate
    run(TO - 1, 1'b0, 1'b0, 1'b1, "R6");
    run(1, 1'b1, 1'b0, 1'b1, "R6");
    run(TO - 1, 1'b0, 1'b0, 1'b1, "R6");
    run(1, 1'b1, 1'b0, 1'b1, "R6");
    // R5: exact limit trips, R7: stays tripped while low
    run(TO, 1'b0, 1'b0, 1'b1, "R5");
    run(10, 1'b0, 1'b0, 1'b1, "R7");
    run(2, 1'b1, 1'b0, 1'b1, "R7");
    // R10: timer runs with mode off too
    run(TO, 1'b0, 1'b0, 1'b0, "R10");
    run(1, 1'b1, 1'b0, 1'b1, "R10");
    // R8: fault with txd high, R9: stays while fault present
    run(3, 1'b1, 1'b1, 1'b1, "R8");
    run(1, 1'b0, 1'b1, 1'b1, "R9");
    run(3, 1'b0, 1'b0, 1'b1, "R9");
    run(2, 1'b1, 1'b0, 1'b1, "R9");
    // R8: fault while dominant
    run(2, 1'b0, 1'b1, 1'b1, "R8");
    run(1, 1'b1, 1'b1, 1'b1, "R9");
    run(2, 1'b1, 1'b0, 1'b1, "R9");
    // both lockouts together
    run(TO + 2, 1'b0, 1'b0, 1'b1, "R5");
    run(2, 1'b0, 1'b1, 1'b1, "R8");
    run(1, 1'b1, 1'b1, 1'b1, "R9");
    run(2, 1'b1, 1'b0, 1'b1, "R7");
    run(2, 1'b0, 1'b0, 1'b1, "R3");
    run(1, 1'b1, 1'b0, 1'b1, "R2");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule